// File: doc/BRIEF.md
# Second-Order Delta-Sigma Bitstream Modulator

This block converts a 16-bit sample code into a one-bit oversampled stream whose average ones density equals the code's share of full scale. A sample divider produces an update strobe once every `DIV` system clocks, and on each strobe a two-integrator noise-shaping loop emits one new bit. A downstream one-bit DAC and its analog filters, which are outside this block, recover the level from that stream.

Before the loop sees the code, an input conditioner does three things. It maps the code from either offset-binary-with-inverted-MSB (two's complement shifted by half scale) or plain unsigned binary to one unsigned level. It scales that level by a gain trim. It adds a signed offset trim and saturates the result to the 16-bit range. A clear input replaces the code with zero. An awake input puts the loop to sleep: the integrators are held at zero and the stream is silenced.

Top module: `dsm2_core`

## Requirements
- R1: While `awake` is high, `bit_vld` pulses for exactly one clock, and consecutive pulses are exactly `DIV` clocks apart.
- R2: With `fmt_bin`=1, unity gain (`gain_trim`=0x8000) and zero offset, the long-run ones density of `bit_out` equals code/65535, within 6/1024.
- R3: With `fmt_bin`=0, the code is read with its bit 15 inverted. So 0x8000 is the bottom of the range, 0x0000 is mid-scale and 0x7FFF is full scale.
- R4: With `clr`=1, the `code` port is ignored and treated as 0x0000. This gives zero density when `fmt_bin`=1 and half density when `fmt_bin`=0.
- R5: `ofs_trim` is a signed two's complement value added to the scaled level in units of one code step.
- R6: The formatted code is multiplied by `gain_trim` and shifted right by 15 bits, so 0x8000 is unity gain and 0x4000 halves the level.
- R7: The corrected level saturates to the range 0 to 65535. Below-range levels give an all-zero stream and above-range levels give an all-ones stream.
- R8: While `awake` is low, `bit_out` and `bit_vld` are low and both integrators are cleared. After waking, a level of 0 gives only zeros and a level of 65535 gives only ones after the first bit.
- R9: For levels between 4096 and 61440, neither integrator ever reaches its saturation rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| awake | input | 1 | Loop runs when high; sleep when low |
| clr | input | 1 | Replace the code with zero |
| fmt_bin | input | 1 | 1 = plain binary code, 0 = MSB-inverted code |
| code | input | 16 | Sample code |
| gain_trim | input | 16 | Unsigned gain, 0x8000 = unity |
| ofs_trim | input | 16 | Signed offset in code steps |
| bit_out | output | 1 | Modulator output bit |
| bit_vld | output | 1 | Strobe marking a new output bit |

## Verification
The integrator-rail assertion assumes the corrected level stays in the band from 4096 to 61440 whenever the loop state is non-zero. Stuck levels of 0 or 65535 are only safe when they start from cleared integrators. For that reason every random trial rejects code and trim draws whose level falls outside the band. Every saturation and extreme-code case is preceded by a sleep period that clears the loop. The clear-input assertions assume unity gain and zero offset only in the cases where they check an exact level.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

    typedef enum logic {
        FMT_SHIFTED = 1'b0,
        FMT_PLAIN   = 1'b1
    } code_fmt_t;

    localparam int DSM2_CODE_W = 16;
    localparam int DSM2_GAIN_FRAC = 15;

endpackage

// File: rtl/dsm2_tick.sv
module dsm2_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNTW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);
    localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    generate
        if (POW2) begin : g_wrap
            always_comb begin
                st_d = st_q;
                st_d.cnt = en ? st_q.cnt + 1'b1 : '0;
            end
        end else begin : g_cmp
            always_comb begin
                st_d = st_q;
                if (!en || st_q.cnt == LAST) st_d.cnt = '0;
                else                        st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = en && (st_q.cnt == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

    initial begin
        AST_DIV_MIN: assert (DIV >= 2); // R1
    end
endmodule

// File: rtl/dsm2_cond.sv
module dsm2_cond #(
    parameter int CW    = 16,
    parameter int GW    = 16,
    parameter int GFRAC = 15,
    parameter int OW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 fmt_bin,
    input  logic [CW-1:0]        code,
    input  logic [GW-1:0]        gain,
    input  logic signed [OW-1:0] ofs,
    output logic [CW-1:0]        level
);
    localparam int PW  = CW + GW;
    localparam int SCW = PW - GFRAC;
    localparam int SW  = ((SCW > OW) ? SCW : OW) + 2;
    localparam logic [CW-1:0] MSB_FLIP = {1'b1, {(CW-1){1'b0}}};
    localparam logic [GW-1:0] UNITY = GW'(1) << GFRAC;

    typedef struct packed {
        logic [CW-1:0] level;
    } cond_st_t;

    cond_st_t st_d, st_q;

    logic [CW-1:0]        raw;
    logic [CW-1:0]        uval;
    logic [PW-1:0]        prod;
    logic [SCW-1:0]       scaled;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] fs;

    always_comb begin
        raw    = clr ? '0 : code;
        uval   = (fmt_bin == dsm2_pkg::FMT_PLAIN) ? raw : (raw ^ MSB_FLIP);
        prod   = {{GW{1'b0}}, uval} * {{CW{1'b0}}, gain};
        scaled = prod[PW-1:GFRAC];
        sum    = $signed({{(SW-SCW){1'b0}}, scaled}) + $signed({{(SW-OW){ofs[OW-1]}}, ofs});
        fs     = $signed({{(SW-CW){1'b0}}, {CW{1'b1}}});
        st_d   = st_q;
        if (sum < 0)       st_d.level = '0;
        else if (sum > fs) st_d.level = '1;
        else               st_d.level = sum[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;

    AST_CLR_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && fmt_bin && ofs == '0) |=> level == '0); // R4

    AST_CLR_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fmt_bin && gain == UNITY && ofs == '0) |=> level == MSB_FLIP); // R4

    AST_UNITY_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && fmt_bin && gain == UNITY && ofs == '0) |=> level == $past(code)); // R2
endmodule

// File: rtl/dsm2_loop.sv
module dsm2_loop #(
    parameter int CW = 16,
    parameter int IW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] level,
    output logic          bit_out,
    output logic          bit_vld
);
    localparam int EW = IW + 2;
    localparam logic signed [IW-1:0] IMAX = {1'b0, {(IW-1){1'b1}}};
    localparam logic signed [IW-1:0] IMIN = {1'b1, {(IW-1){1'b0}}};
    localparam logic signed [EW-1:0] EMAX = {2'b00, 1'b0, {(IW-1){1'b1}}};
    localparam logic signed [EW-1:0] EMIN = {2'b11, 1'b1, {(IW-1){1'b0}}};

    typedef struct packed {
        logic signed [IW-1:0] i1;
        logic signed [IW-1:0] i2;
        logic                 b;
        logic                 vld;
    } loop_st_t;

    loop_st_t st_d, st_q;

    function automatic logic signed [IW-1:0] clip(input logic signed [EW-1:0] v);
        if (v > EMAX)      return IMAX;
        else if (v < EMIN) return IMIN;
        else               return v[IW-1:0];
    endfunction

    logic                 y;
    logic signed [EW-1:0] x_e;
    logic signed [EW-1:0] fb_e;
    logic signed [IW-1:0] i1_n;
    logic signed [IW-1:0] i2_n;

    always_comb begin
        y    = (st_q.i2 > 0);
        x_e  = $signed({{(EW-CW){1'b0}}, level});
        fb_e = y ? $signed({{(EW-CW){1'b0}}, {CW{1'b1}}}) : '0;
        i1_n = clip($signed({{2{st_q.i1[IW-1]}}, st_q.i1}) + x_e - fb_e);
        i2_n = clip($signed({{2{st_q.i2[IW-1]}}, st_q.i2})
                    + $signed({{2{i1_n[IW-1]}}, i1_n}) - fb_e);
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            st_d.i1  = i1_n;
            st_d.i2  = i2_n;
            st_d.b   = y;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_out = st_q.b;
    assign bit_vld = st_q.vld;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.i1 != IMAX && st_q.i1 != IMIN && st_q.i2 != IMAX && st_q.i2 != IMIN); // R9

    AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.i1 == '0 && st_q.i2 == '0)); // R8
endmodule

// File: rtl/dsm2_core.sv
module dsm2_core #(
    parameter int CW    = dsm2_pkg::DSM2_CODE_W,
    parameter int GW    = 16,
    parameter int GFRAC = dsm2_pkg::DSM2_GAIN_FRAC,
    parameter int OW    = 16,
    parameter int IW    = 24,
    parameter int DIV   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 awake,
    input  logic                 clr,
    input  logic                 fmt_bin,
    input  logic [CW-1:0]        code,
    input  logic [GW-1:0]        gain_trim,
    input  logic signed [OW-1:0] ofs_trim,
    output logic                 bit_out,
    output logic                 bit_vld
);
    logic          tick;
    logic [CW-1:0] level;

    dsm2_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (awake),
        .tick  (tick)
    );

    dsm2_cond #(.CW(CW), .GW(GW), .GFRAC(GFRAC), .OW(OW)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .fmt_bin (fmt_bin),
        .code    (code),
        .gain    (gain_trim),
        .ofs     (ofs_trim),
        .level   (level)
    );

    dsm2_loop #(.CW(CW), .IW(IW)) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (awake),
        .tick    (tick),
        .level   (level),
        .bit_out (bit_out),
        .bit_vld (bit_vld)
    );

    AST_VLD_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(awake)); // R1

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> (!bit_vld && !bit_out)); // R8
endmodule

// File: tb/sim_dsm2_core.sv
`timescale 1ns/1ps
module sim_dsm2_core;
    localparam int DIV_T = 3;
    localparam int NBITS = 1024;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               awake = 1'b0;
    logic               clr = 1'b0;
    logic               fmt_bin = 1'b1;
    logic [15:0]        code = '0;
    logic [15:0]        gain_trim = 16'h8000;
    logic signed [15:0] ofs_trim = '0;
    logic               bit_out;
    logic               bit_vld;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dsm2_core #(.DIV(DIV_T)) u0 (
        .clk(clk), .rst_n(rst_n), .awake(awake), .clr(clr), .fmt_bin(fmt_bin),
        .code(code), .gain_trim(gain_trim), .ofs_trim(ofs_trim),
        .bit_out(bit_out), .bit_vld(bit_vld)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected < 190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic longint exp_level(input logic [15:0] c, input bit binf, input bit cl,
                                         input logic [15:0] g, input logic signed [15:0] o);
        longint u, s;
        u = cl ? 0 : longint'(c);
        if (!binf) u = u ^ 32768;
        s = ((u * longint'(g)) >>> 15) + longint'(o);
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        return s;
    endfunction

    task automatic check(input string req, input longint act, input longint expv, input bit ok);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic collect(input int n, output int ones);
        int k = 0;
        ones = 0;
        while (k < n) begin
            @(negedge clk);
            if (bit_vld) begin
                k++;
                ones += int'(bit_out);
            end
        end
    endtask

    task automatic sleep_wake(input string req);
        @(negedge clk);
        awake = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(req, {bit_vld, bit_out}, 0, !bit_vld && !bit_out);
        end
        awake = 1'b1;
    endtask

    task automatic density(input string req, input longint lvl, input int tol);
        int     ones;
        longint err;
        collect(64, ones);
        collect(NBITS, ones);
        err = longint'(ones) * 65535 - lvl * NBITS;
        if (err < 0) err = -err;
        check(req, ones, (lvl * NBITS) / 65535, err <= longint'(tol) * 65535);
    endtask

    task automatic apply(input logic [15:0] c, input bit binf, input bit cl,
                         input logic [15:0] g, input logic signed [15:0] o);
        @(negedge clk);
        code = c; fmt_bin = binf; clr = cl; gain_trim = g; ofs_trim = o;
    endtask

    initial begin
        int gap, ones;
        longint lvl;
        logic [15:0] rc, rg;
        logic signed [15:0] ro;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset", {bit_vld, bit_out}, 0, !bit_vld && !bit_out);

        apply(16'h4000, 1'b1, 1'b0, 16'h8000, 16'sd0);
        awake = 1'b1;
        // R1: strobe spacing
        collect(2, ones);
        for (int j = 0; j < 3; j++) begin
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!bit_vld);
            check("R1 strobe gap", gap, DIV_T, gap == DIV_T);
        end

        // R2: plain binary density
        density("R2 plain 0x4000", 16'h4000, 6);
        apply(16'hC000, 1'b1, 1'b0, 16'h8000, 16'sd0);
        density("R2 plain 0xC000", 16'hC000, 6);

        // R3: shifted format
        apply(16'h0000, 1'b0, 1'b0, 16'h8000, 16'sd0);
        density("R3 shifted 0x0000 mid", 32768, 6);
        apply(16'h8000, 1'b0, 1'b0, 16'h8000, 16'sd0);
        sleep_wake("R8 sleep");
        density("R3 shifted 0x8000 bottom", 0, 0);
        apply(16'h7FFF, 1'b0, 1'b0, 16'h8000, 16'sd0);
        sleep_wake("R8 sleep");
        density("R3 shifted 0x7FFF top", 65535, 0);

        // R4: clear ignores code
        apply(16'h1234, 1'b0, 1'b1, 16'h8000, 16'sd0);
        density("R4 clr shifted mid", 32768, 6);
        apply(16'hBEEF, 1'b1, 1'b1, 16'h8000, 16'sd0);
        sleep_wake("R8 sleep");
        density("R4 clr plain zero", 0, 0);

        // R6: gain
        apply(16'h8000, 1'b1, 1'b0, 16'h4000, 16'sd0);
        density("R6 half gain", 16'h4000, 6);
        apply(16'hA000, 1'b1, 1'b0, 16'h6000, 16'sd0);
        density("R6 0.75 gain", 16'h7800, 6);

        // R5: offset
        apply(16'h8000, 1'b1, 1'b0, 16'h8000, 16'sh1000);
        density("R5 plus offset", 16'h9000, 6);
        apply(16'h8000, 1'b1, 1'b0, 16'h8000, -16'sh2000);
        density("R5 minus offset", 16'h6000, 6);

        // R7: saturation
        apply(16'hF000, 1'b1, 1'b0, 16'h8000, 16'sh2000);
        sleep_wake("R8 sleep");
        density("R7 sat high", 65535, 0);
        apply(16'h0800, 1'b1, 1'b0, 16'h8000, -16'sh1000);
        sleep_wake("R8 sleep");
        density("R7 sat low", 0, 0);
        apply(16'hFFFF, 1'b1, 1'b0, 16'h8000, 16'sd0);
        sleep_wake("R8 sleep");
        density("R8 wake full scale", 65535, 0);

        // random in-band trials (R2 R5 R6 R9)
        for (int t = 0; t < 8; t++) begin
            do begin
                rc  = 16'($urandom);
                rg  = 16'h6000 + 16'($urandom_range(0, 16'h4000));
                ro  = 16'($signed(17'($urandom_range(0, 4096)) - 17'sd2048));
                lvl = exp_level(rc, t[0], 1'b0, rg, ro);
            end while (lvl < 4096 || lvl > 61440);
            apply(rc, t[0], 1'b0, rg, ro);
            density("R9 random trim", lvl, 6);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule